// File: doc/BRIEF.md
# Speculative Store Path with Undo

This block is the store side of a small direct-mapped data cache that never makes a store wait for its tag compare. When a store is accepted, the indexed data line is overwritten at once. In the same cycle the line's previous contents are read through a second read port and parked, with the index, in a one-entry undo register. The tag lookup (stored tag plus valid bit) is registered and resolves in the following cycle. A hit simply drops the parked copy. A miss reports the miss to the requester and, in that same cycle, writes the parked copy back into the line, so the wrong write never becomes visible as lasting state.

Loads use an asynchronous read port addressed by index. While a line is being repaired, a load of that line is served from the undo register instead of the array. A separate line-install port places data, a tag and a valid bit into one line. It stands in for a refill engine, which is outside this block.

Top module: `spec_wr_cache`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `st_ready` is 1 and `st_resp` and `st_miss` are 0. After reset every line is invalid, so any store misses.
- R2: A store is accepted on a rising edge where `st_valid` and `st_ready` are both 1. In the next cycle `st_resp` is 1, and `st_miss` is 1 exactly when that line was not both valid and tagged with `st_tag` at acceptance. `st_resp` is 0 in every cycle that does not follow an accepted store.
- R3: On a hit, the new data stays in the line. A load of that index returns the stored data from the cycle after acceptance onward.
- R4: On a miss, the line is restored to its contents from before the store. A load of that index returns those old contents during the cycle that reports the miss and in every later cycle.
- R5: `st_ready` is 0 in exactly the cycle that reports a miss. A store offered in that cycle is not accepted, and it is accepted on the next edge if it is still offered.
- R6: A line whose valid bit is 0 misses, even when its stored tag equals the store's tag.
- R7: The line-install port writes data, tag and valid bit of `ln_idx` when `ln_we` is 1, `st_valid` is 0 and `st_ready` is 1, and the new data is readable in the next cycle. An install offered while `st_valid` is 1 has no effect.
- R8: Stores that hit may be accepted on consecutive edges with no gap. A store to the same index right after another one replaces it, and the line ends with the later data.
- R9: During a repair cycle, a load of any other index returns that line's array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_idx | input | IDX_W | Line index of the store |
| st_tag | input | TAG_W | Tag of the store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store (and install) can be taken this cycle |
| st_resp | output | 1 | Tag result for the store accepted on the previous edge |
| st_miss | output | 1 | That store missed; its line is being repaired this cycle |
| ld_idx | input | IDX_W | Load index |
| ld_data | output | DATA_W | Load data, combinational from `ld_idx` |
| ln_we | input | 1 | Line install request |
| ln_idx | input | IDX_W | Line to install |
| ln_tag | input | TAG_W | Tag to install |
| ln_vld | input | 1 | Valid bit to install (0 invalidates) |
| ln_data | input | DATA_W | Data to install |

## Verification
The bench builds the block with IDX_W=3, TAG_W=6 and DATA_W=16. Eight lines let one scenario install and read back every line and still leave spare lines for aliasing and neighbour checks. The short tag makes it cheap to write a matching tag into an invalid line, which puts the valid-bit miss case within reach. With these values the bench can also place a miss, a stalled store and a load of both the repaired line and a neighbour in adjacent cycles.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // source selected for the single data-array write port
  typedef enum logic [1:0] {
    WSRC_NONE    = 2'd0,
    WSRC_STORE   = 2'd1,
    WSRC_RESTORE = 2'd2,
    WSRC_LINE    = 2'd3
  } swc_wsrc_e;
endpackage

// File: rtl/swc_data_array.sv
module swc_data_array #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int N_RD   = 2
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_RD-1:0][IDX_W-1:0]    rd_idx,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // one write port, no reset on storage
  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  // asynchronous read ports
  generate
    for (genvar g = 0; g < N_RD; g++) begin : g_rd
      assign rd_data[g] = mem_q[rd_idx[g]];
    end
  endgenerate
endmodule

// File: rtl/swc_tag_store.sv
module swc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic             wvld,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (we) begin
      valid_d[widx] = wvld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[widx] <= wtag;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/swc_undo_buf.sv
module swc_undo_buf #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [DATA_W-1:0] cap_old,
  input  logic              cap_hit,
  output logic              pend_vld,
  output logic              restore_en,
  output logic [IDX_W-1:0]  restore_idx,
  output logic [DATA_W-1:0] restore_old
);
  logic              vld_q, vld_d;
  logic              hit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] old_q;

  // a new entry is captured for every accepted store
  always_comb begin
    vld_d = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      hit_q <= cap_hit;
      idx_q <= cap_idx;
      old_q <= cap_old;
    end
  end

  assign pend_vld    = vld_q;
  assign restore_en  = vld_q && !hit_q;
  assign restore_idx = idx_q;
  assign restore_old = old_q;
endmodule

// File: rtl/spec_wr_cache.sv
module spec_wr_cache
  import swc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  output logic              st_resp,
  output logic              st_miss,
  input  logic [IDX_W-1:0]  ld_idx,
  output logic [DATA_W-1:0] ld_data,
  input  logic              ln_we,
  input  logic [IDX_W-1:0]  ln_idx,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic              ln_vld,
  input  logic [DATA_W-1:0] ln_data
);
  localparam int N_RD   = 2;
  localparam int RD_LD  = 0;
  localparam int RD_OLD = 1;

  logic                        restore_en;
  logic [IDX_W-1:0]            restore_idx;
  logic [DATA_W-1:0]           restore_old;
  logic                        pend_vld;
  logic                        st_acc;
  logic                        ln_acc;
  logic                        lk_hit;
  swc_wsrc_e                   wsrc;
  logic                        arr_we;
  logic [IDX_W-1:0]            arr_widx;
  logic [DATA_W-1:0]           arr_wdata;
  logic [N_RD-1:0][IDX_W-1:0]  arr_ridx;
  logic [N_RD-1:0][DATA_W-1:0] arr_rdata;

  // the repair write owns the port; new stores and installs wait
  assign st_ready = !restore_en;
  assign st_acc   = st_valid && st_ready;
  assign ln_acc   = ln_we && !st_valid && st_ready;

  always_comb begin
    wsrc = WSRC_NONE;
    if (restore_en) begin
      wsrc = WSRC_RESTORE;
    end else if (st_acc) begin
      wsrc = WSRC_STORE;
    end else if (ln_acc) begin
      wsrc = WSRC_LINE;
    end
  end

  always_comb begin
    arr_we    = 1'b0;
    arr_widx  = '0;
    arr_wdata = '0;
    unique case (wsrc)
      WSRC_RESTORE: begin
        arr_we    = 1'b1;
        arr_widx  = restore_idx;
        arr_wdata = restore_old;
      end
      WSRC_STORE: begin
        arr_we    = 1'b1;
        arr_widx  = st_idx;
        arr_wdata = st_data;
      end
      WSRC_LINE: begin
        arr_we    = 1'b1;
        arr_widx  = ln_idx;
        arr_wdata = ln_data;
      end
      default: begin
        arr_we = 1'b0;
      end
    endcase
  end

  always_comb begin
    arr_ridx         = '0;
    arr_ridx[RD_LD]  = ld_idx;
    arr_ridx[RD_OLD] = st_idx;
  end

  swc_data_array #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .N_RD  (N_RD)
  ) u_data (
    .clk    (clk),
    .we     (arr_we),
    .widx   (arr_widx),
    .wdata  (arr_wdata),
    .rd_idx (arr_ridx),
    .rd_data(arr_rdata)
  );

  swc_tag_store #(
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ln_acc),
    .widx  (ln_idx),
    .wtag  (ln_tag),
    .wvld  (ln_vld),
    .lk_idx(st_idx),
    .lk_tag(st_tag),
    .lk_hit(lk_hit)
  );

  swc_undo_buf #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_undo (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (st_acc),
    .cap_idx    (st_idx),
    .cap_old    (arr_rdata[RD_OLD]),
    .cap_hit    (lk_hit),
    .pend_vld   (pend_vld),
    .restore_en (restore_en),
    .restore_idx(restore_idx),
    .restore_old(restore_old)
  );

  // a load of the line under repair sees the saved copy
  always_comb begin
    if (restore_en && (ld_idx == restore_idx)) begin
      ld_data = restore_old;
    end else begin
      ld_data = arr_rdata[RD_LD];
    end
  end

  assign st_resp = pend_vld;
  assign st_miss = restore_en;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic [IDX_W-1:0]  st_idx,
  input logic [TAG_W-1:0]  st_tag,
  input logic [DATA_W-1:0] st_data,
  input logic              st_ready,
  input logic              st_resp,
  input logic              st_miss,
  input logic [IDX_W-1:0]  ld_idx,
  input logic [DATA_W-1:0] ld_data
);
  logic unused_tag;
  assign unused_tag = ^st_tag;

  // R1: idle outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_idle_r1: assert (st_ready && !st_resp && !st_miss);
    end
  end

  p_resp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> st_resp);

  p_no_resp_without_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && st_ready) |=> !st_resp);

  p_miss_has_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |-> st_resp);

  p_hit_data_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_resp && !st_miss && (ld_idx == $past(st_idx))) |-> (ld_data == $past(st_data)));

  p_stall_on_repair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |-> !st_ready);

  p_ready_after_repair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |=> (st_ready && !st_miss));
endmodule

bind spec_wr_cache swc_checker #(
  .IDX_W (IDX_W),
  .TAG_W (TAG_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .st_valid(st_valid),
  .st_idx  (st_idx),
  .st_tag  (st_tag),
  .st_data (st_data),
  .st_ready(st_ready),
  .st_resp (st_resp),
  .st_miss (st_miss),
  .ld_idx  (ld_idx),
  .ld_data (ld_data)
);

// File: tb/spec_wr_cache_bench.sv
module spec_wr_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 3;
  localparam int TW = 6;
  localparam int DW = 16;
  localparam int NL = 1 << IW;

  logic          clk;
  logic          rst_n;
  logic          st_valid;
  logic [IW-1:0] st_idx;
  logic [TW-1:0] st_tag;
  logic [DW-1:0] st_data;
  logic          st_ready;
  logic          st_resp;
  logic          st_miss;
  logic [IW-1:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic          ln_we;
  logic [IW-1:0] ln_idx;
  logic [TW-1:0] ln_tag;
  logic          ln_vld;
  logic [DW-1:0] ln_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DW-1:0] ref_data [NL];
  logic [TW-1:0] ref_tag  [NL];
  bit            ref_vld  [NL];
  bit            ref_kn   [NL];

  spec_wr_cache #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) u_spec_wr_cache (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_idx(st_idx), .st_tag(st_tag), .st_data(st_data),
    .st_ready(st_ready), .st_resp(st_resp), .st_miss(st_miss),
    .ld_idx(ld_idx), .ld_data(ld_data),
    .ln_we(ln_we), .ln_idx(ln_idx), .ln_tag(ln_tag), .ln_vld(ln_vld), .ln_data(ln_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ld_chk(input logic [IW-1:0] idx, input logic [DW-1:0] exp, input string req);
    ld_idx = idx;
    #1;
    chk(ld_data === exp, req, 32'(ld_data), 32'(exp));
  endtask

  task automatic install(input logic [IW-1:0] idx, input logic [TW-1:0] tag,
                         input bit vld, input logic [DW-1:0] data);
    @(negedge clk);
    ln_we = 1'b1; ln_idx = idx; ln_tag = tag; ln_vld = vld; ln_data = data;
    @(negedge clk);
    ln_we = 1'b0;
    ref_data[idx] = data; ref_tag[idx] = tag; ref_vld[idx] = vld; ref_kn[idx] = 1'b1;
    ld_chk(idx, data, "R7 install readback");
  endtask

  task automatic store_op(input logic [IW-1:0] idx, input logic [TW-1:0] tag,
                          input logic [DW-1:0] data, input string req);
    bit exp_miss;
    logic [DW-1:0] old;
    exp_miss = !(ref_vld[idx] && ref_tag[idx] == tag);
    old = ref_data[idx];
    @(negedge clk);
    st_valid = 1'b1; st_idx = idx; st_tag = tag; st_data = data;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_resp === 1'b1, {req, " R2 resp"}, 32'(st_resp), 1);
    chk(st_miss === exp_miss, {req, " R2 miss flag"}, 32'(st_miss), 32'(exp_miss));
    if (exp_miss) begin
      chk(st_ready === 1'b0, {req, " R5 stall in repair"}, 32'(st_ready), 0);
      if (ref_kn[idx]) ld_chk(idx, old, {req, " R4 load during repair"});
      @(negedge clk);
      chk(st_resp === 1'b0 && st_ready === 1'b1, {req, " R5 idle after repair"},
          32'({st_resp, st_ready}), 32'b01);
      if (ref_kn[idx]) ld_chk(idx, old, {req, " R4 restored"});
    end else begin
      ld_chk(idx, data, {req, " R3 hit data"});
      ref_data[idx] = data;
    end
  endtask

  task automatic t_reset;
    #1;
    chk(st_ready === 1'b1 && st_resp === 1'b0 && st_miss === 1'b0, "R1 outputs in reset",
        32'({st_ready, st_resp, st_miss}), 32'b100);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_ready === 1'b1 && st_resp === 1'b0, "R1 outputs after reset",
        32'({st_ready, st_resp}), 32'b10);
    store_op(3'd6, 6'h11, 16'h1234, "R1 store after reset misses");
  endtask

  task automatic t_fill;
    for (int i = 0; i < NL; i++) install(3'(i), 6'(i + 5), 1'b1, 16'hA000 + 16'(i));
  endtask

  task automatic t_hit;
    store_op(3'd2, 6'd7, 16'hBEEF, "R3 hit idx2");
  endtask

  task automatic t_tag_miss;
    store_op(3'd1, 6'h3F, 16'hDEAD, "R4 tag mismatch idx1");
  endtask

  task automatic t_invalid;
    install(3'd5, 6'h33, 1'b0, 16'h5555);
    store_op(3'd5, 6'h33, 16'h7777, "R6 invalid line with equal tag");
  endtask

  task automatic t_stall;
    @(negedge clk);
    st_valid = 1'b1; st_idx = 3'd1; st_tag = 6'h20; st_data = 16'h0BAD;
    @(negedge clk);
    chk(st_miss === 1'b1 && st_ready === 1'b0, "R5 miss then stall",
        32'({st_miss, st_ready}), 32'b10);
    ld_chk(3'd2, ref_data[2], "R9 neighbour load during repair");
    ld_chk(3'd1, ref_data[1], "R4 repaired line load during repair");
    st_idx = 3'd3; st_tag = 6'd8; st_data = 16'hC0DE;
    @(negedge clk);
    chk(st_resp === 1'b0 && st_ready === 1'b1, "R5 stalled store not taken",
        32'({st_resp, st_ready}), 32'b01);
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_resp === 1'b1 && st_miss === 1'b0, "R5 stalled store taken next",
        32'({st_resp, st_miss}), 32'b10);
    ld_chk(3'd3, 16'hC0DE, "R5 stalled store data");
    ref_data[3] = 16'hC0DE;
    ld_chk(3'd1, ref_data[1], "R4 line after repair");
  endtask

  task automatic t_b2b;
    for (int k = 0; k <= 4; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk(st_resp === 1'b1 && st_miss === 1'b0, "R8 back-to-back hit",
            32'({st_resp, st_miss}), 32'b10);
      end
      if (k < 4) begin
        st_valid = 1'b1; st_idx = 3'(k); st_tag = 6'(k + 5); st_data = 16'h4000 + 16'(k);
        ref_data[k] = 16'h4000 + 16'(k);
      end else begin
        st_valid = 1'b0;
      end
    end
    for (int k = 0; k < 4; k++) ld_chk(3'(k), 16'h4000 + 16'(k), "R8 back-to-back data");
    @(negedge clk);
    st_valid = 1'b1; st_idx = 3'd2; st_tag = 6'd7; st_data = 16'h1111;
    @(negedge clk);
    st_data = 16'h2222;
    @(negedge clk);
    st_valid = 1'b0;
    chk(st_resp === 1'b1 && st_miss === 1'b0, "R8 same index pair",
        32'({st_resp, st_miss}), 32'b10);
    ld_chk(3'd2, 16'h2222, "R8 later store wins");
    ref_data[2] = 16'h2222;
  endtask

  task automatic t_install_blocked;
    @(negedge clk);
    st_valid = 1'b1; st_idx = 3'd0; st_tag = 6'd5; st_data = 16'h9090;
    ln_we = 1'b1; ln_idx = 3'd4; ln_tag = 6'h2A; ln_vld = 1'b1; ln_data = 16'hFFFF;
    @(negedge clk);
    st_valid = 1'b0; ln_we = 1'b0;
    chk(st_resp === 1'b1 && st_miss === 1'b0, "R7 store wins over install",
        32'({st_resp, st_miss}), 32'b10);
    ld_chk(3'd4, ref_data[4], "R7 install ignored with store");
    ld_chk(3'd0, 16'h9090, "R3 store beside blocked install");
    ref_data[0] = 16'h9090;
    store_op(3'd4, 6'd9, 16'h4444, "R7 old tag still present");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < NL; i++) ld_chk(3'(i), ref_data[i], "R4 final line contents");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      ref_vld[i] = 1'b0; ref_kn[i] = 1'b0; ref_data[i] = '0; ref_tag[i] = '0;
    end
    rst_n = 1'b0; st_valid = 1'b0; st_idx = '0; st_tag = '0; st_data = '0;
    ld_idx = '0; ln_we = 1'b0; ln_idx = '0; ln_tag = '0; ln_vld = 1'b0; ln_data = '0;
    repeat (3) @(negedge clk);
    t_reset;
    t_fill;
    t_hit;
    t_tag_miss;
    t_invalid;
    t_stall;
    t_b2b;
    t_install_blocked;
    t_sweep;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule